// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Condition Flags

This block is the arithmetic and logic unit of a small 8-bit processor. The accumulator register is always one operand. The second operand is captured into a hidden holding register when the load strobe is raised, together with an operation code. On the clock edge after the capture, the selected operation runs. The block then updates the result register and, depending on the operation, the accumulator and the flag byte.

The operations are add and add-with-carry, subtract and subtract-with-borrow, AND, OR, XOR and compare. Increment and decrement apply to the captured byte, which stands for a register other than the accumulator. A move operation copies the captured byte into the accumulator. Five condition bits are kept: sign, zero, nibble (auxiliary) carry, even parity and carry. They are presented as one byte with a fixed layout.

Top module: `alu8_core`

## Requirements
- R1: While reset is asserted and after it is released, the accumulator and the result are 0x00 and the flag byte is 0x02.
- R2: A load strobe sampled at clock edge k captures the operand byte and the op code. The operation changes the outputs at edge k+1. Strobes on consecutive edges each execute in turn, and each one sees the accumulator written by the operation before it. An edge with no pending operation changes nothing.
- R3: Op codes 0 (add), 1 (add with carry), 2 (subtract) and 3 (subtract with borrow) write the 8-bit result to both the accumulator and the result output. For add, CY is the carry out of bit 7. For subtract, CY is set when a borrow occurs, meaning the minuend is smaller than the subtrahend plus the incoming borrow.
- R4: Op codes 4 (AND), 5 (OR) and 6 (XOR) write the result to the accumulator and the result output, and clear both CY and AC.
- R5: Op code 7 (compare) sets the result output and all five flags exactly as a subtract would, and leaves the accumulator unchanged.
- R6: Op codes 8 (increment) and 9 (decrement) place the operand plus one or minus one (modulo 256) on the result output. They leave the accumulator and CY unchanged and update S, Z, P and AC.
- R7: Op code 10 (move) copies the operand into the accumulator and the result output, and leaves the flags unchanged.
- R8: After any flag-writing operation, S equals bit 7 of the result, Z is set only for a zero result, and P is set only when the result has an even number of ones.
- R9: AC is the carry from bit 3 into bit 4 of the internal 8-bit addition. Subtraction is performed as the minuend plus the inverted subtrahend plus the inverted borrow. Increment is operand plus 1 and decrement is operand plus 0xFF, so decrement sets AC whenever the low nibble of the operand is nonzero.
- R10: Flag byte layout, bit 7 to bit 0: S, Z, 0, AC, 0, P, 1, CY.
- R11: Op codes 11 to 15 change neither the accumulator, the flags nor the result output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code, captured with the strobe |
| operand_i | input | 8 | Second operand byte, captured with the strobe |
| load_i | input | 1 | Load strobe; captures op and operand |
| result_o | output | 8 | Result of the last executed operation |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 8 | Flag byte S,Z,0,AC,0,P,1,CY |

## Verification
A corrupted accumulator shows up one cycle later. It appears in the result and flags of the next arithmetic or logic operation, and in acc_o at once. A wrong carry bit stays hidden until an add-with-carry or subtract-with-borrow consumes it, so the stimulus chains these operations after every kind of flag writer. A stuck holding register or pending flag changes the result on the edge after the strobe. A reference model checks every port on every cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned DW  = 8;
  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_MOV = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } cond_t;

  localparam cond_t COND_RST = '{s: 1'b0, z: 1'b0, ac: 1'b0, p: 1'b0, cy: 1'b0};

  function automatic logic [DW-1:0] pack_cond(input cond_t c);
    return {c.s, c.z, 1'b0, c.ac, 1'b0, c.p, 1'b1, c.cy};
  endfunction

endpackage

// File: rtl/alu8_operand_stage.sv
module alu8_operand_stage
  import alu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  operand_i,
  output logic           pend_vld_o,
  output logic [OPW-1:0] pend_op_o,
  output logic [DW-1:0]  pend_opnd_o
);

  logic           vld_d, vld_q;
  logic [OPW-1:0] op_d, op_q;
  logic [DW-1:0]  opnd_d, opnd_q;

  always_comb begin
    vld_d  = load_i;
    op_d   = op_q;
    opnd_d = opnd_q;
    if (load_i) begin
      op_d   = op_i;
      opnd_d = operand_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      op_q   <= '0;
      opnd_q <= '0;
    end else begin
      vld_q  <= vld_d;
      op_q   <= op_d;
      opnd_q <= opnd_d;
    end
  end

  assign pend_vld_o  = vld_q;
  assign pend_op_o   = op_q;
  assign pend_opnd_o = opnd_q;

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (pend_vld_o && pend_opnd_o == $past(operand_i) && pend_op_o == $past(op_i)));

endmodule

// File: rtl/alu8_flag_gen.sv
module alu8_flag_gen
  import alu8_pkg::*;
(
  input  logic [DW-1:0] res_i,
  output logic          sign_o,
  output logic          zero_o,
  output logic          par_o
);

  assign sign_o = res_i[DW-1];
  assign zero_o = ~|res_i;
  assign par_o  = ~^res_i;

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o,
  output logic          res_we_o,
  output logic          acc_we_o,
  output logic          flag_we_o
);

  localparam int unsigned NIB = DW / 2;

  logic [DW-1:0] add_x, add_y;
  logic          add_cin;
  logic [DW:0]   sum;
  logic          nib_carry;

  // adder operand selection
  always_comb begin
    add_x   = acc_i;
    add_y   = opnd_i;
    add_cin = 1'b0;
    unique case (op_i)
      OP_ADC:         add_cin = cy_i;
      OP_SUB, OP_CMP: begin add_y = ~opnd_i; add_cin = 1'b1;  end
      OP_SBB:         begin add_y = ~opnd_i; add_cin = ~cy_i; end
      OP_INC:         begin add_x = opnd_i; add_y = '0; add_cin = 1'b1; end
      OP_DEC:         begin add_x = opnd_i; add_y = '1; end
      default:        ;
    endcase
  end

  assign sum       = {1'b0, add_x} + {1'b0, add_y} + {{DW{1'b0}}, add_cin};
  assign nib_carry = add_x[NIB] ^ add_y[NIB] ^ sum[NIB];

  // result, flag and write-enable selection
  always_comb begin
    res_o     = sum[DW-1:0];
    cy_o      = cy_i;
    ac_o      = nib_carry;
    res_we_o  = 1'b1;
    acc_we_o  = 1'b0;
    flag_we_o = 1'b1;
    unique case (op_i)
      OP_ADD, OP_ADC: begin cy_o = sum[DW];  acc_we_o = 1'b1; end
      OP_SUB, OP_SBB: begin cy_o = ~sum[DW]; acc_we_o = 1'b1; end
      OP_CMP:         cy_o = ~sum[DW];
      OP_AND: begin res_o = acc_i & opnd_i; cy_o = 1'b0; ac_o = 1'b0; acc_we_o = 1'b1; end
      OP_OR:  begin res_o = acc_i | opnd_i; cy_o = 1'b0; ac_o = 1'b0; acc_we_o = 1'b1; end
      OP_XOR: begin res_o = acc_i ^ opnd_i; cy_o = 1'b0; ac_o = 1'b0; acc_we_o = 1'b1; end
      OP_INC, OP_DEC: ;
      OP_MOV: begin res_o = opnd_i; acc_we_o = 1'b1; flag_we_o = 1'b0; end
      default: begin res_we_o = 1'b0; flag_we_o = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  operand_i,
  input  logic           load_i,
  output logic [DW-1:0]  result_o,
  output logic [DW-1:0]  acc_o,
  output logic [DW-1:0]  flags_o
);

  logic           pend_vld;
  logic [OPW-1:0] pend_op_raw;
  logic [DW-1:0]  pend_opnd;
  alu_op_e        pend_op;

  logic [DW-1:0]  dp_res;
  logic           dp_cy, dp_ac, dp_res_we, dp_acc_we, dp_flag_we;
  logic           fg_s, fg_z, fg_p;

  logic [DW-1:0]  acc_d, acc_q, res_d, res_q;
  cond_t          cond_d, cond_q;

  alu8_operand_stage u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .op_i        (op_i),
    .operand_i   (operand_i),
    .pend_vld_o  (pend_vld),
    .pend_op_o   (pend_op_raw),
    .pend_opnd_o (pend_opnd)
  );

  assign pend_op = alu_op_e'(pend_op_raw);

  alu8_datapath u_dp (
    .op_i      (pend_op),
    .acc_i     (acc_q),
    .opnd_i    (pend_opnd),
    .cy_i      (cond_q.cy),
    .res_o     (dp_res),
    .cy_o      (dp_cy),
    .ac_o      (dp_ac),
    .res_we_o  (dp_res_we),
    .acc_we_o  (dp_acc_we),
    .flag_we_o (dp_flag_we)
  );

  alu8_flag_gen u_fg (
    .res_i  (dp_res),
    .sign_o (fg_s),
    .zero_o (fg_z),
    .par_o  (fg_p)
  );

  always_comb begin
    acc_d  = acc_q;
    res_d  = res_q;
    cond_d = cond_q;
    if (pend_vld) begin
      if (dp_res_we)  res_d  = dp_res;
      if (dp_acc_we)  acc_d  = dp_res;
      if (dp_flag_we) cond_d = '{s: fg_s, z: fg_z, ac: dp_ac, p: fg_p, cy: dp_cy};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      res_q  <= '0;
      cond_q <= COND_RST;
    end else begin
      acc_q  <= acc_d;
      res_q  <= res_d;
      cond_q <= cond_d;
    end
  end

  assign acc_o    = acc_q;
  assign result_o = res_q;
  assign flags_o  = pack_cond(cond_q);

  // R5
  cmp_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && pend_op == OP_CMP) |=> $stable(acc_o));

  // R6
  incdec_cy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && (pend_op == OP_INC || pend_op == OP_DEC)) |=> ($stable(acc_o) && $stable(flags_o[0])));

  // R4
  logic_cy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && (pend_op == OP_AND || pend_op == OP_OR || pend_op == OP_XOR)) |=> (flags_o[0] == 1'b0 && flags_o[4] == 1'b0));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && pend_op_raw <= 4'd9) |=> (flags_o[6] == (result_o == '0) && flags_o[7] == result_o[DW-1]));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_vld |=> ($stable(acc_o) && $stable(flags_o) && $stable(result_o)));

  // R11
  unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && pend_op_raw > 4'd10) |=> ($stable(acc_o) && $stable(flags_o) && $stable(result_o)));

  // R7
  mov_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && pend_op == OP_MOV) |=> ($stable(flags_o) && acc_o == result_o));

endmodule

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic       load_i = 1'b0;
  logic [7:0] result_o, acc_o, flags_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .operand_i(operand_i),
    .load_i(load_i), .result_o(result_o), .acc_o(acc_o), .flags_o(flags_o)
  );

  // behavioural reference state
  int m_acc, m_res, m_s, m_z, m_ac, m_p, m_cy;
  int m_pv, m_op, m_tmp;
  string m_tag = "R1";

  function automatic int even_ones(int v);
    int cnt = 0;
    for (int i = 0; i < 8; i++) if ((v >> i) & 1) cnt++;
    return (cnt % 2 == 0) ? 1 : 0;
  endfunction

  function automatic int model_flags();
    return (m_s << 7) | (m_z << 6) | (m_ac << 4) | (m_p << 2) | 2 | m_cy;
  endfunction

  task automatic set_szp(int r);
    m_s = (r >> 7) & 1;
    m_z = (r == 0) ? 1 : 0;
    m_p = even_ones(r);
  endtask

  task automatic model_exec();
    int a, b, r, lo;
    a = m_acc; b = m_tmp;
    case (m_op)
      0, 1: begin
        r  = a + b + ((m_op == 1) ? m_cy : 0);
        lo = (a % 16) + (b % 16) + ((m_op == 1) ? m_cy : 0);
        m_cy = (r > 255) ? 1 : 0; m_ac = (lo > 15) ? 1 : 0;
        r = r % 256; m_acc = r; m_res = r; set_szp(r); m_tag = "R3";
      end
      2, 3, 7: begin
        int bin;
        bin = (m_op == 3) ? m_cy : 0;
        r  = a - b - bin;
        lo = (a % 16) + (15 - (b % 16)) + (1 - bin);
        m_cy = (r < 0) ? 1 : 0; m_ac = (lo > 15) ? 1 : 0;
        r = (r + 256) % 256; m_res = r; set_szp(r);
        if (m_op != 7) begin m_acc = r; m_tag = "R3"; end else m_tag = "R5";
      end
      4, 5, 6: begin
        r = (m_op == 4) ? (a & b) : (m_op == 5) ? (a | b) : (a ^ b);
        m_cy = 0; m_ac = 0; m_acc = r; m_res = r; set_szp(r); m_tag = "R4";
      end
      8: begin
        r = (b + 1) % 256; m_ac = ((b % 16) == 15) ? 1 : 0;
        m_res = r; set_szp(r); m_tag = "R6";
      end
      9: begin
        r = (b + 255) % 256; m_ac = ((b % 16) != 0) ? 1 : 0;
        m_res = r; set_szp(r); m_tag = "R6";
      end
      10: begin m_acc = b; m_res = b; m_tag = "R7"; end
      default: m_tag = "R11";
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_res = 0; m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
      m_pv = 0; m_op = 0; m_tmp = 0; m_tag = "R1";
    end else begin
      if (m_pv != 0) model_exec();
      else m_tag = "R2";
      m_pv = load_i ? 1 : 0;
      if (load_i) begin m_op = int'(op_i); m_tmp = int'(operand_i); end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int ef, af;
    ef = model_flags(); af = int'(flags_o);
    check(m_tag, "acc", int'(acc_o), m_acc);
    check(m_tag, "result", int'(result_o), m_res);
    check("R8", "S/Z/P", af & 8'hC4, ef & 8'hC4);
    check("R9", "AC", af & 8'h10, ef & 8'h10);
    check("R10", "fixed bits", af & 8'h2A, 8'h02);
    check(m_tag, "CY", af & 8'h01, ef & 8'h01);
  endtask

  // one cycle: compare on negedge, then drive next stimulus
  task automatic step(bit ld, int op, int val);
    @(negedge clk);
    compare_all();
    load_i = ld; op_i = 4'(op); operand_i = 8'(val);
  endtask

  initial begin
    #100000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "acc", int'(acc_o), 0);
    check("R1", "result", int'(result_o), 0);
    check("R1", "flags", int'(flags_o), 8'h02);
    rst_n = 1'b1;
    // directed corners
    step(1, 10, 8'h0F);                 // R7 move
    step(1, 0, 8'h01);                  // R9 nibble carry 0F+01
    step(1, 10, 8'hFF);
    step(1, 0, 8'h01);                  // R3 carry + zero
    step(1, 1, 8'h00);                  // R3 carry in
    step(1, 10, 8'h10);
    step(1, 2, 8'h20);                  // R3 borrow
    step(1, 3, 8'h00);                  // R3 borrow in
    step(1, 7, 8'hEF);                  // R5 compare equal
    step(1, 7, 8'hF0);                  // R5 compare borrow
    step(1, 4, 8'h0F);                  // R4
    step(1, 5, 8'hA0);
    step(1, 6, 8'hFF);
    step(1, 8, 8'hFF);                  // R6 increment wrap
    step(1, 9, 8'h00);                  // R6 decrement wrap
    step(1, 9, 8'h10);                  // R9 dec low nibble zero
    step(1, 12, 8'h55);                 // R11 unused op
    step(1, 15, 8'hAA);
    step(0, 0, 8'h00);                  // R2 idle
    step(0, 0, 8'h00);
    step(1, 2, 8'h01);
    step(0, 0, 8'h00);
    // mixed stimulus with gaps
    for (int i = 0; i < 4000; i++) begin
      int opv = $urandom_range(0, 15);
      if (opv > 11) opv = $urandom_range(0, 10);
      step(($urandom_range(0, 3) != 0), opv, $urandom_range(0, 255));
    end
    step(0, 0, 0);
    step(0, 0, 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule